// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps the contents of an SDRAM alive. An interval timer adds one owed refresh at a fixed average rate. The rate is derived from the clock frequency, the retention window and the number of refresh rows. While refreshes are owed and the block is idle, it raises a request to the main command arbiter. The arbiter may postpone the request. Up to a fixed number of refreshes can build up, and a separate urgent flag tells the arbiter when that limit is reached.

When the arbiter grants the request, the block takes the command bus for one full refresh sequence. If the arbiter reports that any bank is open, the block first closes all banks with a precharge-all command and waits out the precharge time. It then issues the auto-refresh command, which carries no address because the device steps its own row counter. Finally it holds the bus with NOP commands until the row cycle time has passed, and then returns the bus to the arbiter. The arbiter keeps the clock-enable pin high. Self refresh and power-down are not handled here.

Top module: `sdram_refresh_sched`

## Requirements
- R1: One refresh becomes owed every INTERVAL = floor(CLK_MHZ * WINDOW_US / ROWS) clock cycles. The first one is owed INTERVAL cycles after reset is released. With the defaults (100, 32000, 2048) INTERVAL is 1562.
- R2: `req` is high exactly when at least one refresh is owed and no sequence is running (`active` low).
- R3: The owed count saturates at MAX_OWED, and further timer ticks are dropped. `urgent` is high exactly when the count equals MAX_OWED.
- R4: A grant (`grant` and `req` high at one clock edge) while any `bank_open` bit is set makes the next cycle a precharge-all command: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1.
- R5: The auto-refresh command comes exactly T_RP cycles after the precharge-all command, with NOP cycles in between.
- R6: A grant while all `bank_open` bits are clear makes the next cycle the auto-refresh command: cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0.
- R7: After the auto-refresh command, `active` stays high with NOP for T_RC-1 more cycles and then drops. The next command the block issues is therefore at least T_RC cycles after the refresh.
- R8: Each auto-refresh command removes exactly one owed refresh. A timer tick in the same cycle leaves the count unchanged.
- R9: While `active` is high, every cycle that is not a precharge or a refresh is a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0). While `active` is low, the block drives deselect (cs_n=1, other pins high, a10=0).
- R10: `grant` has no effect while `req` is low: no command is issued and `active` stays low.
- R11: During reset and right after it, `req`, `urgent` and `active` are low and the outputs show deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | NUM_BANKS | Per-bank open-row status from the arbiter, sampled at the grant edge |
| grant | input | 1 | Arbiter hands the command bus to this block |
| req | output | 1 | A refresh is owed and the block is idle |
| urgent | output | 1 | The owed count is at its limit |
| active | output | 1 | The block owns the command bus |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10, selects all banks for precharge |

## Verification
The checker enforces several rules on every cycle:
- the deselect state while idle;
- that `req` and `active` are never high together;
- that a sequence only starts after a real grant;
- the exact precharge-to-refresh spacing;
- that the bus is held for the row cycle time after each refresh;
- that `urgent` never appears without a pending request or a running sequence.

The absolute refresh interval, the saturation of the owed count, the count of refreshes drained after a backlog, and the choice between precharge-first and refresh-first for each bank pattern depend on arithmetic over long spans. Only the bench scenarios show these, by comparing against a cycle model of the owed count.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECH,
    ST_WAIT_RP,
    ST_REFR,
    ST_WAIT_RC
  } rf_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sdram_cmd_t;

  // Average refresh spacing in clock cycles, rounded down so the rate is never too slow.
  function automatic int unsigned refresh_interval(input int unsigned clk_mhz,
                                                   input int unsigned window_us,
                                                   input int unsigned rows);
    return (clk_mhz * window_us) / rows;
  endfunction

  // Command pin pattern for each sequencer state.
  function automatic sdram_cmd_t cmd_for_state(input rf_state_t s);
    sdram_cmd_t c;
    case (s)
      ST_IDLE:  c = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
      ST_PRECH: c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      ST_REFR:  c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      default:  c = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owed_counter.sv
module owed_counter #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic consume,
  output logic pending,
  output logic full
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] LIMIT = OW'(MAX_OWED);

  logic [OW-1:0] owed;

  assign pending = (owed != '0);
  assign full    = (owed == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      case ({tick, consume})
        2'b10:   if (owed != LIMIT) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)    owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RC      = 7,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pending,
  input  logic                 grant,
  input  logic [NUM_BANKS-1:0] bank_open,
  output rf_state_t            state,
  output logic                 req,
  output logic                 active,
  output logic                 consume
);
  localparam int unsigned TMAX = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int unsigned WCW  = (TMAX > 2) ? $clog2(TMAX) : 1;

  logic [WCW-1:0] wait_cnt;
  logic           start;

  assign req     = pending && (state == ST_IDLE);
  assign start   = req && grant;
  assign active  = (state != ST_IDLE);
  assign consume = (state == ST_REFR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) state <= (|bank_open) ? ST_PRECH : ST_REFR;
        end
        ST_PRECH: begin
          if (T_RP <= 1) begin
            state <= ST_REFR;
          end else begin
            state    <= ST_WAIT_RP;
            wait_cnt <= WCW'(T_RP - 2);
          end
        end
        ST_WAIT_RP: begin
          if (wait_cnt == '0) state <= ST_REFR;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        ST_REFR: begin
          if (T_RC <= 1) begin
            state <= ST_IDLE;
          end else begin
            state    <= ST_WAIT_RC;
            wait_cnt <= WCW'(T_RC - 2);
          end
        end
        ST_WAIT_RC: begin
          if (wait_cnt == '0) state <= ST_IDLE;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned WINDOW_US = 32000,
  parameter int unsigned ROWS      = 2048,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RC      = 7,
  parameter int unsigned MAX_OWED  = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 grant,
  output logic                 req,
  output logic                 urgent,
  output logic                 active,
  output logic                 cmd_cs_n,
  output logic                 cmd_ras_n,
  output logic                 cmd_cas_n,
  output logic                 cmd_we_n,
  output logic                 cmd_a10
);
  localparam int unsigned INTERVAL = refresh_interval(CLK_MHZ, WINDOW_US, ROWS);

  // Internal events, named for the checker and waveforms.
  logic       ev_tick;
  logic       ev_consume;
  logic       owed_pending;
  rf_state_t  seq_state;
  sdram_cmd_t cmd;

  refi_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ev_tick)
  );

  owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (ev_tick),
    .consume(ev_consume),
    .pending(owed_pending),
    .full   (urgent)
  );

  refresh_fsm #(.T_RP(T_RP), .T_RC(T_RC), .NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (owed_pending),
    .grant    (grant),
    .bank_open(bank_open),
    .state    (seq_state),
    .req      (req),
    .active   (active),
    .consume  (ev_consume)
  );

  always_comb cmd = cmd_for_state(seq_state);

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;
  assign cmd_a10   = cmd.a10;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int unsigned T_RP = 3,
  parameter int unsigned T_RC = 7
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic req,
  input logic urgent,
  input logic active,
  input logic cmd_cs_n,
  input logic cmd_ras_n,
  input logic cmd_cas_n,
  input logic cmd_we_n
);
  logic is_ref, is_pre;
  int unsigned since_ref, since_pre;
  logic seen_ref, pre_pend;

  assign is_ref = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n &&  cmd_we_n;
  assign is_pre = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;

  // Counters measure the gaps, so no long $past windows are needed.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= 0;
      since_pre <= 0;
      seen_ref  <= 1'b0;
      pre_pend  <= 1'b0;
    end else begin
      if (is_ref) begin
        since_ref <= 1;
        seen_ref  <= 1'b1;
        pre_pend  <= 1'b0;
      end else if (since_ref <= T_RC) begin
        since_ref <= since_ref + 1;
      end
      if (is_pre) begin
        since_pre <= 1;
        pre_pend  <= 1'b1;
      end else if (since_pre <= T_RP) begin
        since_pre <= since_pre + 1;
      end
    end
  end

  assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cmd_cs_n);

  assert_req_not_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && active));

  assert_start_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(grant && req));

  assert_pre_to_ref_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && pre_pend) |-> (since_pre == T_RP));

  assert_ref_to_ref_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && seen_ref) |-> (since_ref >= T_RC));

  assert_hold_after_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_ref && since_ref < T_RC) |-> active);

  assert_urgent_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> (req || active));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.T_RP(T_RP), .T_RC(T_RC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant),
  .req      (req),
  .urgent   (urgent),
  .active   (active),
  .cmd_cs_n (cmd_cs_n),
  .cmd_ras_n(cmd_ras_n),
  .cmd_cas_n(cmd_cas_n),
  .cmd_we_n (cmd_we_n)
);

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
  localparam int CLK_MHZ   = 2;
  localparam int WINDOW_US = 32000;
  localparam int ROWS      = 2048;
  localparam int T_RP      = 3;
  localparam int T_RC      = 7;
  localparam int MAX_OWED  = 8;
  localparam int NB        = 2;
  localparam int IVL       = (CLK_MHZ * WINDOW_US) / ROWS;  // 31

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic req, urgent, active;
  logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int owed_m = 0;
  bit ref_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .WINDOW_US(WINDOW_US), .ROWS(ROWS),
    .T_RP(T_RP), .T_RC(T_RC), .MAX_OWED(MAX_OWED), .NUM_BANKS(NB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .grant(grant),
    .req(req), .urgent(urgent), .active(active),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_a10(cmd_a10)
  );

  function automatic bit is_ref();
    return !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && !cmd_a10;
  endfunction
  function automatic bit is_pre();
    return !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10;
  endfunction
  function automatic bit is_nop();
    return !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_a10;
  endfunction
  function automatic bit is_desel();
    return cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_a10;
  endfunction
  function automatic int pins();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One clock: update the owed-count model at the edge, then compare at the falling edge.
  task automatic step();
    bit tick;
    @(posedge clk);
    cyc++;
    tick = ((cyc % IVL) == 0);
    if (tick && !ref_seen) begin
      if (owed_m < MAX_OWED) owed_m++;
    end else if (!tick && ref_seen) begin
      owed_m--;
    end
    @(negedge clk);
    chk(req == (owed_m > 0 && !active), "R2 req", req, (owed_m > 0 && !active));
    chk(urgent == (owed_m == MAX_OWED), "R3 urgent", urgent, (owed_m == MAX_OWED));
    ref_seen = is_ref();
  endtask

  task automatic wait_req();
    for (int k = 0; k < 4 * IVL && !req; k++) step();
  endtask

  // Grant one sequence with the given open-bank pattern and check every cycle of it.
  task automatic run_seq(input logic [NB-1:0] banks);
    wait_req();
    grant = 1'b1;
    bank_open = banks;
    step();
    grant = 1'b0;
    bank_open = '0;
    if (banks != '0) begin
      chk(is_pre(), "R4 precharge-all after grant", pins(), 5'b00101);
      for (int k = 1; k < T_RP; k++) begin
        step();
        chk(is_nop() && active, "R9 NOP during tRP", pins(), 5'b01110);
      end
      step();
      chk(is_ref(), "R5 refresh tRP after precharge", pins(), 5'b00010);
    end else begin
      chk(is_ref(), "R6 refresh right after grant", pins(), 5'b00010);
    end
    for (int k = 1; k < T_RC; k++) begin
      step();
      chk(is_nop() && active, "R7 NOP hold during tRC", pins(), 5'b01110);
    end
    step();
    chk(!active && is_desel(), "R7 release after tRC", active, 0);
  endtask

  initial begin
    int first_req;
    int start_cyc, n_ref;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(!req && !urgent && !active, "R11 reset flags", {req, urgent, active}, 0);
    chk(is_desel(), "R11 reset deselect", pins(), 5'b11110);
    rst_n = 1'b1;

    // R10: grant without any owed refresh does nothing
    grant = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk(!active && is_desel(), "R10 grant ignored", pins(), 5'b11110);
    end
    grant = 1'b0;

    // R1: first request appears INTERVAL cycles after reset release
    first_req = -1;
    for (int k = 0; k < 2 * IVL && first_req < 0; k++) begin
      step();
      if (req) first_req = cyc;
    end
    chk(first_req == IVL, "R1 first refresh owed", first_req, IVL);

    // Sweep every open-bank pattern twice
    for (int rep = 0; rep < 2; rep++)
      for (int b = 0; b < (1 << NB); b++) run_seq(NB'(b));

    // R3: let the backlog saturate, then a few more ticks
    for (int k = 0; k < (MAX_OWED + 3) * IVL; k++) step();
    chk(urgent, "R3 saturated urgent", urgent, 1);

    // R8: drain; each refresh removes one, ticks during the drain add more
    start_cyc = cyc;
    n_ref = 0;
    for (int k = 0; k < 3 * MAX_OWED && req; k++) begin
      run_seq(NB'(k % (1 << NB)));
      n_ref++;
    end
    chk(!req && !urgent, "R8 backlog drained", {req, urgent}, 0);
    chk(n_ref == MAX_OWED + (cyc / IVL - start_cyc / IVL), "R8 refresh count",
        n_ref, MAX_OWED + (cyc / IVL - start_cyc / IVL));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule